// File: doc/BRIEF.md
# Masked-Operand Issue Function Unit

This function unit executes one simple ALU operation per issue. A single-cycle issue pulse carries an opcode, a per-port skip vector, a zero-A flag and an immediate with its use flag. The unit then fetches operands over several source ports. Each port has its own request/valid handshake and may answer after any number of cycles, in any order relative to the other ports. Once every operand it needs is held, the unit forms the result (pass A, A+B or A-B). It presents the result on a write port that stays asserted until the consumer acknowledges it.

A port whose skip bit is set is never requested, and its operand reads as zero. The zero-A flag removes the read on port 0. The immediate flag removes the read on port 1 and uses the immediate in place of B, unless the skip bit of port 1 is set, in which case B is zero. Every accepted issue produces exactly one result write, even with every port skipped. While an operation is in flight the unit reports busy and drops any further issue pulse.

Top module: `fu_masked_issue`

## Requirements
- R1: After reset, busy_o, every src_req_o bit and res_req_o are all 0.
- R2: When bit i of skip_i is set at issue, src_req_o[i] stays 0 for the whole operation, and port i sees no transfer.
- R3: A skipped operand is taken as zero in the result (skip = bit 0 for A, bit 1 for B, bit 2 for the third port).
- R4: With zero_a_i set at issue, port 0 is not requested and A is zero; with skip bit 0 also set the result is the same.
- R5: With imm_use_i set and skip bit 1 clear, port 1 is not requested and B equals imm_i; with skip bit 1 set, port 1 is not requested and B is zero.
- R6: Each accepted issue yields exactly one result transfer (res_req_o && res_ack_i), even with all ports skipped; res_req_o and res_data_o hold steady until acknowledged.
- R7: op_i = 0 gives A, 1 gives A+B, 2 gives A-B, all modulo 2^W; code 3 behaves as 0.
- R8: busy_o is 1 from the cycle after the accepted issue edge until the edge that completes the result transfer; an issue pulse while busy_o is 1 is ignored, including one in the cycle of that completing edge.
- R9: res_req_o does not rise while any required operand is still outstanding, whatever order the ports answer in.
- R10: A request on a port stays high until valid is seen with it; data is captured on that edge and the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | 2 | Operation code |
| skip_i | input | NSRC | Per-port read skip, bit i for port i |
| zero_a_i | input | 1 | Force A to zero, no read on port 0 |
| imm_use_i | input | 1 | Use immediate as B, no read on port 1 |
| imm_i | input | W | Immediate value |
| busy_o | output | 1 | Operation in flight |
| src_req_o | output | NSRC | Operand read request per port |
| src_valid_i | input | NSRC | Operand valid per port |
| src_data_i | input | NSRC*W | Operand data, port i at bits i*W +: W |
| res_req_o | output | 1 | Result write request |
| res_ack_i | input | 1 | Result write acknowledge |
| res_data_o | output | W | Result value |

## Verification
The issue input and the completion of the result write can meet in one cycle: the unit is still busy at that edge, so the new pulse must be dropped even though the unit goes idle right after. The bench waits until it sees the write request and acknowledge together, raises issue for exactly that cycle with a different opcode and skip vector, and then judges by the ports. It checks that busy falls and stays low, that no source request rises and that no second write arrives in the following cycles. A second case drops an issue pulse into the middle of operand collection and checks that the result still belongs to the first operation.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam logic [1:0] OPC_PASS = 2'd0;
  localparam logic [1:0] OPC_ADD  = 2'd1;
  localparam logic [1:0] OPC_SUB  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_WRITE  = 2'd2
  } fu_state_e;
endpackage

// File: rtl/fu_alu.sv
module fu_alu
  import fu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OPC_ADD: y = a + b;
      OPC_SUB: y = a - b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/fu_operand_port.sv
module fu_operand_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         need,
  input  logic [W-1:0] preset,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         req_o,
  output logic         have_o,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      have_o <= 1'b0;
      val_o  <= '0;
    end else if (start) begin
      req_o  <= need;
      have_o <= ~need;
      val_o  <= preset;
    end else if (req_o && valid_i) begin
      req_o  <= 1'b0;
      have_o <= 1'b1;
      val_o  <= data_i;
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_o && !valid_i && !start) |=> req_o);

  assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (req_o && valid_i && !start) |=> (have_o && !req_o && val_o == $past(data_i)));
endmodule

// File: rtl/fu_result_port.sv
module fu_result_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ack_i,
  output logic         req_o,
  output logic [W-1:0] data_o,
  output logic         done_o
);
  assign done_o = req_o & ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      data_o <= '0;
    end else if (load) begin
      req_o  <= 1'b1;
      data_o <= din;
    end else if (done_o) begin
      req_o  <= 1'b0;
    end
  end

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(data_o)));
endmodule

// File: rtl/fu_masked_issue.sv
module fu_masked_issue
  import fu_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSRC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [1:0]        op_i,
  input  logic [NSRC-1:0]   skip_i,
  input  logic              zero_a_i,
  input  logic              imm_use_i,
  input  logic [W-1:0]      imm_i,
  output logic              busy_o,
  output logic [NSRC-1:0]   src_req_o,
  input  logic [NSRC-1:0]   src_valid_i,
  input  logic [NSRC*W-1:0] src_data_i,
  output logic              res_req_o,
  input  logic              res_ack_i,
  output logic [W-1:0]      res_data_o
);
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  fu_state_e         state;
  logic              start;
  logic              all_have;
  logic              res_done;
  logic              load_res;
  logic [NSRC-1:0]   need;
  logic [NSRC-1:0]   have;
  logic [NSRC*W-1:0] vals;
  logic [W-1:0]      alu_y;
  logic [1:0]        op_q;
  logic [NSRC-1:0]   skip_q;
  logic              zero_a_q;
  logic              imm_use_q;

  assign start    = issue_i && (state == ST_IDLE);
  assign all_have = &have;
  assign load_res = (state == ST_GATHER) && all_have;
  assign busy_o   = (state != ST_IDLE);

  for (genvar g = 0; g < NSRC; g++) begin : g_port
    logic         drop;
    logic [W-1:0] preset;
    if (g == PORT_A) begin : g_a
      assign drop   = zero_a_i;
      assign preset = '0;
    end else if (g == PORT_B) begin : g_b
      assign drop   = imm_use_i;
      assign preset = (imm_use_i && !skip_i[g]) ? imm_i : '0;
    end else begin : g_x
      assign drop   = 1'b0;
      assign preset = '0;
    end
    assign need[g] = ~skip_i[g] & ~drop;

    fu_operand_port #(.W(W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .need    (need[g]),
      .preset  (preset),
      .valid_i (src_valid_i[g]),
      .data_i  (src_data_i[g*W +: W]),
      .req_o   (src_req_o[g]),
      .have_o  (have[g]),
      .val_o   (vals[g*W +: W])
    );

    assert_skip_no_req_R2: assert property (@(posedge clk) disable iff (rst)
      (busy_o && skip_q[g]) |-> !src_req_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OPC_PASS;
      skip_q    <= '0;
      zero_a_q  <= 1'b0;
      imm_use_q <= 1'b0;
    end else if (start) begin
      op_q      <= op_i;
      skip_q    <= skip_i;
      zero_a_q  <= zero_a_i;
      imm_use_q <= imm_use_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (start)    state <= ST_GATHER;
        ST_GATHER: if (all_have) state <= ST_WRITE;
        ST_WRITE:  if (res_done) state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  fu_alu #(.W(W)) u_alu (
    .op (op_q),
    .a  (vals[PORT_A*W +: W]),
    .b  (vals[PORT_B*W +: W]),
    .y  (alu_y)
  );

  fu_result_port #(.W(W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .load   (load_res),
    .din    (alu_y),
    .ack_i  (res_ack_i),
    .req_o  (res_req_o),
    .data_o (res_data_o),
    .done_o (res_done)
  );

  logic unused_vals;
  assign unused_vals = ^vals;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!res_req_o && src_req_o == '0));

  assert_issue_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && issue_i) |=> ($stable(op_q) && $stable(skip_q)));

  assert_write_after_gather_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(res_req_o) |-> (src_req_o == '0));

  assert_zero_a_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && zero_a_q) |-> !src_req_o[PORT_A]);

  assert_imm_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && imm_use_q) |-> !src_req_o[PORT_B]);

  assert_one_write_R6: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_req_o);
endmodule

// File: tb/fu_masked_issue_bench.sv
module fu_masked_issue_bench;
  localparam int W    = 8;
  localparam int NSRC = 3;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] skip;
    logic       za;
    logic       iu;
    logic [7:0] imm;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic [1:0] da;
    logic [1:0] db;
    logic [1:0] dc;
    logic [1:0] dw;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'b000, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h00, 2'd0, 2'd2, 2'd1, 2'd0, 8'h05},
    '{2'd1, 3'b000, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h07, 2'd2, 2'd1, 2'd0, 2'd2, 8'h07},
    '{2'd2, 3'b000, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h01, 2'd0, 2'd1, 2'd3, 2'd2, 8'h03},
    '{2'd2, 3'b000, 1'b0, 1'b0, 8'h00, 8'h02, 8'h05, 8'h00, 2'd3, 2'd0, 2'd1, 2'd1, 8'hFD},
    '{2'd1, 3'b010, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h00, 2'd2, 2'd1, 2'd0, 2'd0, 8'h05},
    '{2'd1, 3'b001, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h00, 2'd1, 2'd2, 2'd0, 2'd1, 8'h02},
    '{2'd1, 3'b011, 1'b0, 1'b0, 8'h00, 8'h05, 8'h02, 8'h00, 2'd1, 2'd2, 2'd2, 2'd1, 8'h00},
    '{2'd0, 3'b001, 1'b0, 1'b0, 8'h00, 8'h09, 8'h02, 8'h00, 2'd0, 2'd2, 2'd1, 2'd0, 8'h00},
    '{2'd0, 3'b100, 1'b0, 1'b0, 8'h00, 8'h09, 8'h02, 8'h00, 2'd2, 2'd1, 2'd0, 2'd2, 8'h09},
    '{2'd0, 3'b111, 1'b0, 1'b0, 8'h00, 8'h09, 8'h02, 8'h00, 2'd2, 2'd1, 2'd0, 2'd2, 8'h00},
    '{2'd1, 3'b000, 1'b1, 1'b0, 8'h00, 8'h09, 8'h02, 8'h00, 2'd1, 2'd3, 2'd0, 2'd0, 8'h02},
    '{2'd1, 3'b000, 1'b0, 1'b1, 8'h10, 8'h09, 8'h02, 8'h00, 2'd3, 2'd1, 2'd2, 2'd1, 8'h19},
    '{2'd1, 3'b010, 1'b0, 1'b1, 8'h10, 8'h09, 8'h02, 8'h00, 2'd0, 2'd0, 2'd0, 2'd3, 8'h09},
    '{2'd1, 3'b001, 1'b1, 1'b1, 8'h04, 8'h09, 8'h02, 8'h00, 2'd1, 2'd1, 2'd1, 2'd0, 8'h04},
    '{2'd2, 3'b000, 1'b1, 1'b0, 8'h00, 8'h09, 8'h03, 8'h00, 2'd0, 2'd2, 2'd1, 2'd1, 8'hFD},
    '{2'd1, 3'b000, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h01, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              issue_i = 1'b0;
  logic [1:0]        op_i = '0;
  logic [NSRC-1:0]   skip_i = '0;
  logic              zero_a_i = 1'b0;
  logic              imm_use_i = 1'b0;
  logic [W-1:0]      imm_i = '0;
  logic              busy_o;
  logic [NSRC-1:0]   src_req_o;
  logic [NSRC-1:0]   src_valid_i;
  logic [NSRC*W-1:0] src_data_i;
  logic              res_req_o;
  logic              res_ack_i;
  logic [W-1:0]      res_data_o;

  int         pdly [NSRC];
  logic [7:0] pval [NSRC];
  int         pcnt [NSRC];
  int         xfer [NSRC];
  int         wdly, wcnt, wr_count;
  logic [7:0] wr_last;
  int         checks = 0;
  int         fails = 0;
  int         cycles = 0;

  always #5 clk = ~clk;

  fu_masked_issue #(.W(W), .NSRC(NSRC)) u_fu_masked_issue (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .skip_i(skip_i),
    .zero_a_i(zero_a_i), .imm_use_i(imm_use_i), .imm_i(imm_i), .busy_o(busy_o),
    .src_req_o(src_req_o), .src_valid_i(src_valid_i), .src_data_i(src_data_i),
    .res_req_o(res_req_o), .res_ack_i(res_ack_i), .res_data_o(res_data_o)
  );

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      src_valid_i[i]         = src_req_o[i] && (pcnt[i] == pdly[i]);
      src_data_i[i*W +: W]   = pval[i];
    end
    res_ack_i = res_req_o && (wcnt == wdly);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        pcnt[i] <= 0;
        xfer[i] <= 0;
      end
      wcnt     <= 0;
      wr_count <= 0;
      wr_last  <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (src_req_o[i]) begin
          if (src_valid_i[i]) begin
            pcnt[i] <= 0;
            xfer[i] <= xfer[i] + 1;
          end else begin
            pcnt[i] <= pcnt[i] + 1;
          end
        end
      end
      if (res_req_o) begin
        if (res_ack_i) begin
          wcnt     <= 0;
          wr_count <= wr_count + 1;
          wr_last  <= res_data_o;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n < 200, req, n, 0);
  endtask

  task automatic load_vec(input vec_t v);
    pdly[0] = int'(v.da); pdly[1] = int'(v.db); pdly[2] = int'(v.dc);
    pval[0] = v.a; pval[1] = v.b; pval[2] = v.c;
    wdly = int'(v.dw);
    op_i = v.op; skip_i = v.skip; zero_a_i = v.za;
    imm_use_i = v.iu; imm_i = v.imm;
  endtask

  task automatic run_vec(input vec_t v);
    int pre_x [NSRC];
    int pre_w;
    bit needed;
    for (int i = 0; i < NSRC; i++) pre_x[i] = xfer[i];
    pre_w = wr_count;
    load_vec(v);
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after issue", busy_o, 1);
    wait_idle("R6 write completes");
    check(wr_count == pre_w + 1, "R6 one write", wr_count - pre_w, 1);
    check(wr_last == v.exp, "R7/R3/R4/R5 result", wr_last, v.exp);
    for (int i = 0; i < NSRC; i++) begin
      needed = !v.skip[i] && !(i == 0 && v.za) && !(i == 1 && v.iu);
      check(xfer[i] - pre_x[i] == (needed ? 1 : 0), "R2/R4/R5 port reads",
            xfer[i] - pre_x[i], needed ? 1 : 0);
    end
  endtask

  initial begin
    vec_t v;
    int pre_w;
    int pre_x0;
    for (int i = 0; i < NSRC; i++) begin
      pdly[i] = 0;
      pval[i] = '0;
    end
    wdly = 0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    check(src_req_o == '0, "R1 req reset", src_req_o, 0);
    check(res_req_o == 1'b0, "R1 write reset", res_req_o, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R9 / R10: slow port 0 keeps its request and holds off the write
    v = VEC[1];
    v.da = 2'd3;
    load_vec(v);
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(src_req_o[0] == 1'b1, "R10 request held", src_req_o[0], 1);
    check(res_req_o == 1'b0, "R9 no early write", res_req_o, 0);
    wait_idle("R9 completes");
    check(wr_last == 8'h07, "R9 result", wr_last, 8'h07);

    // R8: issue during operand gathering is dropped
    v = VEC[2];
    v.da = 2'd3; v.db = 2'd3; v.dw = 2'd2;
    load_vec(v);
    pre_w = wr_count;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    @(negedge clk);
    op_i = 2'd1; skip_i = 3'b111;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    wait_idle("R8 gather completes");
    check(wr_last == 8'h03, "R8 mid-gather issue ignored", wr_last, 8'h03);
    check(wr_count == pre_w + 1, "R8 single write", wr_count - pre_w, 1);

    // R8: issue in the very cycle the write completes is dropped
    v = VEC[0];
    v.dw = 2'd2;
    load_vec(v);
    pre_w = wr_count;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    for (int n = 0; n < 50 && !(res_req_o && res_ack_i); n++) @(negedge clk);
    check(res_req_o && res_ack_i, "R8 write handshake seen", res_ack_i, 1);
    pre_x0 = xfer[0];
    op_i = 2'd1; skip_i = 3'b000;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    check(busy_o == 1'b0, "R8 idle after collision", busy_o, 0);
    repeat (5) @(negedge clk);
    check(busy_o == 1'b0 && src_req_o == '0, "R8 collision issue ignored",
          src_req_o, 0);
    check(wr_count == pre_w + 1, "R6 no extra write", wr_count - pre_w, 1);
    check(xfer[0] == pre_x0, "R8 no extra read", xfer[0] - pre_x0, 0);
    check(wr_last == 8'h05, "R7 collision result", wr_last, 8'h05);

    finish_run();
  end
endmodule